// File: doc/BRIEF.md
# Steerable PWM Generator with Dead-Band

This block generates a pulse-width modulated waveform from a 10-bit time base and routes it to four output pins. The time base is an 8-bit period counter with two low-order phase bits below it, so each period count lasts four input clocks. One period lasts (period + 1) × 4 input clocks. The pulse is active from the start of each period until the time base reaches a 10-bit duty value.

Software configures the block through a byte-wide write port. The values it writes land in shadow registers. Period, duty, steering mode and polarity move into their working copies only at a period boundary, so a write never produces a partial or glitched pulse. The dead-band length is the one exception: it is copied at the duty match or at the period boundary, whichever comes first. A steering mode selects one of four routings: a single output, a forward full bridge, a complementary half bridge with dead-band, or a reverse full bridge. Two polarity bits invert the pins pairwise.

When the block is enabled it waits one phase cycle of four clocks, and the first period starts at the counter reset that follows. Until then every pin sits at its inactive level.

Top module: `pwm_bridge_gen`

## Requirements
- R1: With the block running, the time base runs from 0 to {period, 2'b11} and then restarts. One period is therefore (period + 1) × 4 clocks long.
- R2: In single mode (mode 0), pin A is active while the time base is below the working duty value. It goes inactive in the cycle the time base equals the duty value.
- R3: A duty value of 0 keeps the pulse inactive for the whole period.
- R4: A duty value of at least (period + 1) × 4 keeps the pulse active for the whole period.
- R5: A write to period, duty, mode or polarity does not change the pins before the next period boundary.
- R6: While disabled, and for the four clocks after enable rises, every pin is inactive. A pin goes inactive one clock after enable falls.
- R7: Polarity bit 0 inverts pins A and C, and polarity bit 1 inverts pins B and D. The inactive level of a pin equals its polarity bit.
- R8: In forward mode (mode 1), pin A is held active, pin D carries the pulse, and pins B and C are inactive.
- R9: In half-bridge mode (mode 2), pin A carries the pulse and pin B its complement. Every rising edge of either pin is delayed by the dead-band count in clocks, and a count of 0 adds no delay. The two pins are never active together.
- R10: In reverse mode (mode 3), pin C is held active, pin B carries the pulse, and pins A and D are inactive.
- R11: A dead-band write takes effect at the first duty match or period boundary after it, whichever comes first.
- R12: Pins that the selected mode does not use sit at their inactive level.
- R13: Register map for the write port:
  - address 0: period.
  - address 1: duty bits 9:2.
  - address 2: mode in data bits 7:6, duty bits 1:0 in data bits 5:4, and polarity in data bits 1:0.
  - address 3: dead-band count in data bits 5:0.
  - All registers reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Runs the time base when high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 8 | Write data |
| pins | output | 4 | Outputs {D, C, B, A} after polarity |

## Verification
The assertions assume that a write never arrives on the same clock as the load it would affect. Under that assumption a working register changes only at a load point. They also assume that mode 2 is the only mode with a complementary pair. The stimulus always writes a few clocks after a period boundary or a duty match, never on one. It switches modes only from a running state, so that every mode change passes through a period boundary. The dead-band value it uses stays well below the half-period, so each delayed edge is visible inside the window.

// File: rtl/pwm_bridge_pkg.sv
package pwm_bridge_pkg;
   typedef enum logic [1:0] {
      STEER_SINGLE = 2'd0,
      STEER_FWD    = 2'd1,
      STEER_HALF   = 2'd2,
      STEER_REV    = 2'd3
   } steer_mode_t;

   localparam logic [1:0] REG_PERIOD = 2'd0;
   localparam logic [1:0] REG_DUTYHI = 2'd1;
   localparam logic [1:0] REG_CTRL   = 2'd2;
   localparam logic [1:0] REG_DBAND  = 2'd3;

   localparam int CTRL_MODE_LSB = 6;
   localparam int CTRL_DLO_LSB  = 4;
   localparam int NUM_PINS      = 4;
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
   parameter int PER_W = 8,
   parameter int PH_W  = 2,
   localparam int TB_W = PER_W + PH_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic [PER_W-1:0] per_act,
   output logic [TB_W-1:0]  tb,
   output logic             started,
   output logic             wrap
);
   localparam logic [PH_W-1:0] PH_LAST = {PH_W{1'b1}};

   // Before the first reset the counter only walks one phase cycle.
   always_comb begin
      if (!enable)
         wrap = 1'b0;
      else if (started)
         wrap = (tb == {per_act, PH_LAST});
      else
         wrap = (tb[PH_W-1:0] == PH_LAST);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tb      <= '0;
         started <= 1'b0;
      end else if (!enable) begin
         tb      <= '0;
         started <= 1'b0;
      end else if (wrap) begin
         tb      <= '0;
         started <= 1'b1;
      end else begin
         tb      <= tb + 1'b1;
      end
   end
endmodule

// File: rtl/pwm_shadow_regs.sv
module pwm_shadow_regs
   import pwm_bridge_pkg::*;
#(
   parameter int PER_W  = 8,
   parameter int PH_W   = 2,
   parameter int DB_W   = 6,
   parameter int DATA_W = 8,
   localparam int TB_W  = PER_W + PH_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              started,
   input  logic              wrap,
   input  logic [TB_W-1:0]   tb,
   output logic [PER_W-1:0]  per_act,
   output logic [TB_W-1:0]   duty_act,
   output steer_mode_t       mode_act,
   output logic [1:0]        pol_act,
   output logic [DB_W-1:0]   db_act
);
   logic [PER_W-1:0] per_sh;
   logic [TB_W-1:0]  duty_sh;
   steer_mode_t      mode_sh;
   logic [1:0]       pol_sh;
   logic [DB_W-1:0]  db_sh;
   logic             ld_main;
   logic             ld_db;

   assign ld_main = wrap || !started;
   assign ld_db   = ld_main || (started && (tb == duty_act));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         per_sh  <= '0;
         duty_sh <= '0;
         mode_sh <= STEER_SINGLE;
         pol_sh  <= '0;
         db_sh   <= '0;
      end else if (wr_en) begin
         case (wr_addr)
            REG_PERIOD: per_sh <= wr_data[PER_W-1:0];
            REG_DUTYHI: duty_sh[TB_W-1:PH_W] <= wr_data[PER_W-1:0];
            REG_CTRL: begin
               mode_sh              <= steer_mode_t'(wr_data[CTRL_MODE_LSB +: 2]);
               duty_sh[PH_W-1:0]    <= wr_data[CTRL_DLO_LSB +: PH_W];
               pol_sh               <= wr_data[1:0];
            end
            default:    db_sh <= wr_data[DB_W-1:0];
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         per_act  <= '0;
         duty_act <= '0;
         mode_act <= STEER_SINGLE;
         pol_act  <= '0;
      end else if (ld_main) begin
         per_act  <= per_sh;
         duty_act <= duty_sh;
         mode_act <= mode_sh;
         pol_act  <= pol_sh;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         db_act <= '0;
      else if (ld_db)
         db_act <= db_sh;
   end
endmodule

// File: rtl/pwm_steer.sv
module pwm_steer
   import pwm_bridge_pkg::*;
#(
   parameter int TB_W = 10,
   parameter int DB_W = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                started,
   input  logic [TB_W-1:0]     tb,
   input  logic [TB_W-1:0]     duty_act,
   input  steer_mode_t         mode_act,
   input  logic [1:0]          pol_act,
   input  logic [DB_W-1:0]     db_act,
   output logic [NUM_PINS-1:0] pins
);
   logic                raw;
   logic [NUM_PINS-1:0] want;
   logic                use_db;

   assign raw    = started && (tb < duty_act);
   assign use_db = (mode_act == STEER_HALF);

   // want is ordered {D, C, B, A}
   always_comb begin
      case (mode_act)
         STEER_SINGLE: want = {1'b0, 1'b0, 1'b0, raw};
         STEER_FWD:    want = {raw, 1'b0, 1'b0, started};
         STEER_HALF:   want = {1'b0, 1'b0, started && !raw, raw};
         default:      want = {1'b0, started, raw, 1'b0};
      endcase
   end

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      logic [DB_W-1:0] hold_cnt;
      logic            act;

      // Counts how long the wanted level has been active, saturating.
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            hold_cnt <= '0;
         else if (!want[i])
            hold_cnt <= '0;
         else if (hold_cnt != {DB_W{1'b1}})
            hold_cnt <= hold_cnt + 1'b1;
      end

      assign act     = want[i] && (!use_db || (hold_cnt >= db_act));
      assign pins[i] = act ^ pol_act[i % 2];
   end
endmodule

// File: rtl/pwm_bridge_gen.sv
module pwm_bridge_gen
   import pwm_bridge_pkg::*;
#(
   parameter int PER_W  = 8,
   parameter int PH_W   = 2,
   parameter int DB_W   = 6,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [3:0]        pins
);
   localparam int TB_W = PER_W + PH_W;

   if (PER_W > DATA_W) begin : g_bad_per
      $error("period width exceeds write data width");
   end
   if (PH_W < 1 || PH_W > 2) begin : g_bad_ph
      $error("phase width must be 1 or 2");
   end
   if (DB_W > DATA_W) begin : g_bad_db
      $error("dead-band width exceeds write data width");
   end

   logic [TB_W-1:0]  tb;
   logic             started;
   logic             wrap;
   logic [PER_W-1:0] per_act;
   logic [TB_W-1:0]  duty_act;
   steer_mode_t      mode_act;
   logic [1:0]       pol_act;
   logic [DB_W-1:0]  db_act;

   pwm_timebase #(.PER_W(PER_W), .PH_W(PH_W)) u_tb (
      .clk(clk), .rst_n(rst_n), .enable(enable), .per_act(per_act),
      .tb(tb), .started(started), .wrap(wrap)
   );

   pwm_shadow_regs #(.PER_W(PER_W), .PH_W(PH_W), .DB_W(DB_W), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .started(started), .wrap(wrap), .tb(tb),
      .per_act(per_act), .duty_act(duty_act), .mode_act(mode_act),
      .pol_act(pol_act), .db_act(db_act)
   );

   pwm_steer #(.TB_W(TB_W), .DB_W(DB_W)) u_steer (
      .clk(clk), .rst_n(rst_n), .started(started), .tb(tb),
      .duty_act(duty_act), .mode_act(mode_act), .pol_act(pol_act),
      .db_act(db_act), .pins(pins)
   );
endmodule

// File: rtl/pwm_bridge_gen_chk.sv
module pwm_bridge_gen_chk
   import pwm_bridge_pkg::*;
#(
   parameter int PER_W = 8,
   parameter int PH_W  = 2,
   localparam int TB_W = PER_W + PH_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic             started,
   input logic             wrap,
   input logic [TB_W-1:0]  tb,
   input logic [PER_W-1:0] per_act,
   input logic [TB_W-1:0]  duty_act,
   input steer_mode_t      mode_act,
   input logic [1:0]       pol_act,
   input logic [3:0]       pins
);
   logic [3:0] idle_lvl;
   logic [3:0] act;
   assign idle_lvl = {pol_act[1], pol_act[0], pol_act[1], pol_act[0]};
   assign act      = pins ^ idle_lvl;

   assert_tb_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
      started |-> (tb <= {per_act, {PH_W{1'b1}}}));

   assert_shadow_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (started && !wrap) |=> ($stable(duty_act) && $stable(per_act)
                              && $stable(mode_act) && $stable(pol_act)));

   assert_idle_inactive_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !started |-> (act == 4'b0000));

   assert_fwd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (started && mode_act == STEER_FWD) |-> (act[0] && act[2:1] == 2'b00));

   assert_half_no_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_act == STEER_HALF) |-> !(act[0] && act[1]));

   assert_rev_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (started && mode_act == STEER_REV) |-> (act[2] && !act[0] && !act[3]));

   assert_unused_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_act == STEER_SINGLE) |-> (act[3:1] == 3'b000));
endmodule

bind pwm_bridge_gen pwm_bridge_gen_chk #(.PER_W(PER_W), .PH_W(PH_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .started(started), .wrap(wrap), .tb(tb),
   .per_act(per_act), .duty_act(duty_act), .mode_act(mode_act),
   .pol_act(pol_act), .pins(pins)
);

// File: tb/pwm_bridge_gen_test.sv
`timescale 1ns/1ps
module pwm_bridge_gen_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       enable = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = 2'd0;
   logic [7:0] wr_data = 8'd0;
   logic [3:0] pins;

   int checks = 0;
   int fails = 0;
   logic [1:0] cur_pol = 2'b00;

   always #2.5 clk = ~clk;

   pwm_bridge_gen uut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .pins(pins)
   );

   // Reference model built from the requirements
   logic       m_s;
   logic [9:0] m_tb;
   logic [7:0] m_per, s_per;
   logic [9:0] m_duty, s_duty;
   logic [1:0] m_mode, s_mode, m_pol, s_pol;
   logic [5:0] m_db, s_db;
   logic [5:0] m_cnt [4];

   function automatic logic [3:0] want_of(logic s, logic [9:0] t, logic [9:0] du, logic [1:0] m);
      logic r;
      r = s && (t < du);
      case (m)
         2'd0: return {1'b0, 1'b0, 1'b0, r};
         2'd1: return {r, 1'b0, 1'b0, s};
         2'd2: return {1'b0, 1'b0, s && !r, r};
         default: return {1'b0, s, r, 1'b0};
      endcase
   endfunction

   function automatic logic [3:0] model_pins();
      logic [3:0] w, p;
      w = want_of(m_s, m_tb, m_duty, m_mode);
      for (int i = 0; i < 4; i++)
         p[i] = (w[i] && (m_mode != 2'd2 || m_cnt[i] >= m_db)) ^ m_pol[i % 2];
      return p;
   endfunction

   typedef struct { logic [3:0] exp; string tag; } item_t;
   item_t sb_q[$];

   task automatic push_expect(logic [3:0] e, string tag);
      item_t it;
      it.exp = e;
      it.tag = tag;
      sb_q.push_back(it);
   endtask

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_s = 0; m_tb = 0; m_per = 0; s_per = 0; m_duty = 0; s_duty = 0;
         m_mode = 0; s_mode = 0; m_pol = 0; s_pol = 0; m_db = 0; s_db = 0;
         for (int i = 0; i < 4; i++) m_cnt[i] = 0;
      end else begin
         logic wr_wrap, ld, hit;
         logic [3:0] w;
         wr_wrap = enable && (m_s ? (m_tb == {m_per, 2'b11}) : (m_tb[1:0] == 2'b11));
         ld  = wr_wrap || !m_s;
         hit = m_s && (m_tb == m_duty);
         w   = want_of(m_s, m_tb, m_duty, m_mode);
         for (int i = 0; i < 4; i++)
            m_cnt[i] = !w[i] ? 6'd0 : (m_cnt[i] == 6'h3f ? m_cnt[i] : m_cnt[i] + 6'd1);
         if (ld) begin m_per = s_per; m_duty = s_duty; m_mode = s_mode; m_pol = s_pol; end
         if (ld || hit) m_db = s_db;
         if (!enable) begin m_tb = 0; m_s = 0; end
         else if (wr_wrap) begin m_tb = 0; m_s = 1; end
         else m_tb = m_tb + 10'd1;
         if (wr_en) begin
            case (wr_addr)
               2'd0: s_per = wr_data;
               2'd1: s_duty[9:2] = wr_data;
               2'd2: begin s_mode = wr_data[7:6]; s_duty[1:0] = wr_data[5:4]; s_pol = wr_data[1:0]; end
               default: s_db = wr_data[5:0];
            endcase
         end
         push_expect(model_pins(),
                     !m_s ? "R6" : (m_mode == 2'd0 ? "R2" : m_mode == 2'd1 ? "R8" :
                                    m_mode == 2'd2 ? "R9" : "R10"));
      end
   end

   // Monitor: pops expected items and compares them with the pins
   always @(negedge clk) begin
      while (sb_q.size() > 0) begin
         item_t it;
         it = sb_q.pop_front();
         checks++;
         if (pins !== it.exp) begin
            fails++;
            $display("FAIL %s: pins=%b expected=%b at %0t", it.tag, pins, it.exp, $time);
         end
      end
   end

   task automatic check(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wr(logic [1:0] a, logic [7:0] d);
      @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
      @(negedge clk); wr_en = 0;
   endtask

   task automatic wait_boundary();
      @(negedge clk);
      while (!(m_s && m_tb == 0)) @(negedge clk);
   endtask

   // Counts active cycles of each pin from this negedge up to the next period start
   task automatic count_to_wrap(output int hi [4], output int len);
      for (int i = 0; i < 4; i++) hi[i] = 0;
      len = 0;
      do begin
         for (int i = 0; i < 4; i++) if (pins[i] ^ cur_pol[i % 2]) hi[i]++;
         len++;
         @(negedge clk);
      end while (!(m_s && m_tb == 0));
   endtask

   task automatic measure(output int hi [4], output int len);
      wait_boundary();
      count_to_wrap(hi, len);
   endtask

   initial begin
      #1000000;
      fails++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      int hi [4];
      int len;
      repeat (3) @(negedge clk);
      check("R13 reset pins", int'(pins), 0);
      rst_n = 1;
      wr(2'd0, 8'd4);           // period 4 -> 20 clocks
      wr(2'd1, 8'd2);           // duty 8
      wr(2'd2, 8'h00);
      @(negedge clk); enable = 1;
      repeat (3) @(negedge clk);
      check("R6 inactive after enable", int'(pins), 0);
      measure(hi, len);
      check("R1 period length", len, 20);
      check("R2 single duty", hi[0], 8);
      check("R12 unused pins", hi[1] + hi[2] + hi[3], 0);

      wr(2'd1, 8'd0);           // duty 0
      measure(hi, len);
      check("R3 zero duty", hi[0], 0);

      wait_boundary();
      wr(2'd1, 8'd4);           // duty 16, written mid period
      count_to_wrap(hi, len);
      check("R5 old duty kept", hi[0], 0);
      measure(hi, len);
      check("R5 new duty", hi[0], 16);

      wr(2'd1, 8'hff); wr(2'd2, 8'h30);  // duty 1023
      measure(hi, len);
      check("R4 full duty", hi[0], 20);

      wr(2'd1, 8'd2); wr(2'd2, 8'h03);   // duty 8, both polarities inverted
      wait_boundary();
      cur_pol = 2'b11;
      count_to_wrap(hi, len);
      check("R7 inverted duty", hi[0], 8);
      check("R7 idle level", int'(pins[3:1]), 7);

      wr(2'd2, 8'h40); cur_pol = 2'b00;  // forward
      wait_boundary();
      measure(hi, len);
      check("R8 A held", hi[0], 20);
      check("R8 D pulse", hi[3], 8);

      wr(2'd3, 8'd3); wr(2'd2, 8'h80);   // half bridge, dead-band 3
      wait_boundary();
      measure(hi, len);
      check("R9 A delayed", hi[0], 5);
      check("R9 B delayed", hi[1], 9);

      wait_boundary();
      wr(2'd3, 8'd1);           // lands at tb=1, loads at duty match
      count_to_wrap(hi, len);
      check("R11 early dead-band load", hi[1], 11);

      wr(2'd2, 8'hc0);          // reverse
      wait_boundary();
      measure(hi, len);
      check("R10 C held", hi[2], 20);
      check("R10 B pulse", hi[1], 8);
      check("R10 A D idle", hi[0] + hi[3], 0);

      @(negedge clk); enable = 0;
      @(negedge clk);
      check("R6 inactive after disable", int'(pins), 0);
      repeat (4) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule